// File: doc/BRIEF.md
# Per-Port Input Debounce Filter

This block sits between the synchronized input pins of an eight-pin port and the logic that reads them or raises interrupts from them. Each pin can be filtered on its own: a filtered pin moves its output to a new level only once the raw input has held that level for a programmed number of millisecond ticks. A pin that is not filtered passes its raw level straight through.

All pins of the port share one 8-bit debounce time register, counted in millisecond ticks, so the largest time is 255 ticks. Each pin has its own enable bit, its own tick counter and its own two-state machine. The enables are written through a masked write: the upper byte of the write data selects which pins are updated and the lower byte carries their new values, so one pin can be changed without reading back the others. The millisecond tick is a one-cycle pulse that comes from outside the block.

Each pin machine has two states. STEADY means the output agrees with the raw input. SETTLE means the raw input differs from the output and ticks are being counted. There are four transitions. STEADY to SETTLE happens on the first cycle the raw input differs from the output (the "mismatch" transition). SETTLE to STEADY happens in three ways: the raw input returns to the output level (the "cancel" transition), a tick brings the count to the programmed time and the output takes the raw level (the "commit" transition), or the pin becomes bypassed (the "bypass" transition).

Top module: `dbn_port_filter`

## Requirements
- R1: After reset the time register is 0, all enables are 0, every pin machine is in STEADY with a cleared counter, and `pin_out` equals `raw_pins`, which for a zero input is 8'h00.
- R2: A bus write to address 8'h18 loads `bus_wdata[7:0]` into the shared time register; any value from 0 to 255 is accepted and the new time applies from the next clock edge.
- R3: A bus write to address 8'h30 updates pin enable i to `bus_wdata[i]` only where mask bit `bus_wdata[8+i]` is 1; enables whose mask bit is 0 keep their value.
- R4: A pin whose enable is 0 drives `pin_out[i]` equal to `raw_pins[i]` in the same cycle.
- R5: When the time register is 0, every pin passes its raw input through in the same cycle, whatever its enable.
- R6: With enable 1 and time N > 0, after the raw level first differs from the output, the output takes the new level at the clock edge that samples the Nth tick; a tick in the cycle of the first difference is not counted.
- R7: If the raw level returns to the output level before the Nth tick, the output does not change and the pin's counter restarts from zero at the next difference.
- R8: Each pin counts its own ticks, so pins whose raw levels change at different times commit at different ticks under the shared time.
- R9: Bus writes to any address other than 8'h18 and 8'h30 change neither the time register nor the enables.
- R10: Turning on filtering for a pin whose raw level is steady does not change its output, because a bypassed pin's filtered level follows its raw input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_pins | input | 8 | Synchronized raw pin levels |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register write address |
| bus_wdata | input | 16 | Register write data |
| pin_out | output | 8 | Filtered pin levels |

## Verification
A bypassed pin's result is due in the same cycle as the raw change, so it is checked in the first sample after the clock edge that follows the change. A filtered pin's result is due just after the clock edge that samples the Nth tick, and it stays at the old level on every earlier sample. Register writes take effect at the edge that samples the strobe. The driver tags each expected value with the index of the clock edge after which it must hold. The monitor compares in a slot 2 ns after that edge, so every check lands on a fixed, known cycle and never on an edge.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    // Per-pin filter machine: output agrees with raw, or a change is being timed
    typedef enum logic [0:0] {
        ST_STEADY = 1'b0,
        ST_SETTLE = 1'b1
    } dbn_state_e;

endpackage

// File: rtl/dbn_regs.sv
module dbn_regs #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 2 * NPINS,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h18,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [CNT_W-1:0]  dbc_time,
    output logic [NPINS-1:0]  pin_en
);

    logic             hit_cnt;
    logic             hit_en;
    logic [NPINS-1:0] wr_mask;
    logic [NPINS-1:0] wr_val;

    assign hit_cnt = bus_wr && (bus_addr == CNT_ADDR);
    assign hit_en  = bus_wr && (bus_addr == EN_ADDR);
    assign wr_val  = bus_wdata[NPINS-1:0];
    assign wr_mask = bus_wdata[2*NPINS-1:NPINS];

    // Shared time register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbc_time <= '0;
        end else if (hit_cnt) begin
            dbc_time <= bus_wdata[CNT_W-1:0];
        end
    end

    // Masked per-pin enables
    for (genvar i = 0; i < NPINS; i++) begin : g_en
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pin_en[i] <= 1'b0;
            end else if (hit_en && wr_mask[i]) begin
                pin_en[i] <= wr_val[i];
            end
        end
    end

    // R3: pins outside the write mask keep their enable
    a_r3_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        hit_en |=> (((pin_en ^ $past(pin_en)) & ~$past(wr_mask)) == '0));

    // R9: the time register moves only on its own address
    a_r9_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_cnt |=> $stable(dbc_time));

    // R9: enables move only on their own address
    a_r9_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_en |=> $stable(pin_en));

endmodule

// File: rtl/dbn_pin_fsm.sv
module dbn_pin_fsm
    import dbn_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_in,
    input  logic             tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] limit,
    output logic             pin_out
);

    localparam int unsigned EXT_W = CNT_W + 1;

    dbn_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, filt_d;
    logic             bypass;
    logic             differ;
    logic [EXT_W-1:0] cnt_next;
    logic             reach;

    assign bypass   = !enable || (limit == '0);
    assign differ   = raw_in != filt_q;
    assign cnt_next = {1'b0, cnt_q} + EXT_W'(1);
    assign reach    = tick && (cnt_next >= {1'b0, limit});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STEADY;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and next counter/output values
    always_comb begin
        state_d = state_q;
        cnt_d   = '0;
        filt_d  = filt_q;
        unique case (state_q)
            ST_STEADY: begin
                if (bypass) begin
                    filt_d = raw_in;
                end else if (differ) begin
                    state_d = ST_SETTLE;          // mismatch
                end
            end
            ST_SETTLE: begin
                if (bypass) begin
                    state_d = ST_STEADY;          // bypass
                    filt_d  = raw_in;
                end else if (!differ) begin
                    state_d = ST_STEADY;          // cancel
                end else if (reach) begin
                    state_d = ST_STEADY;          // commit
                    filt_d  = raw_in;
                end else if (tick) begin
                    cnt_d = cnt_next[CNT_W-1:0];
                end else begin
                    cnt_d = cnt_q;
                end
            end
        endcase
    end

    // Counter and filtered level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            filt_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    always_comb begin
        pin_out = bypass ? raw_in : filt_q;
    end

    // R6: a filtered level never moves without a tick
    a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !tick) |=> $stable(filt_q));

    // R7: a steady pin holds a cleared counter
    a_r7_steady_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEADY) |-> (cnt_q == '0));

    // R6: a filtered commit only comes out of the timing state
    a_r6_commit_from_settle: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && (state_q == ST_STEADY)) |=> $stable(filt_q));

endmodule

// File: rtl/dbn_port_filter.sv
module dbn_port_filter #(
    parameter int unsigned NPINS  = 8,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CNT_ADDR = 8'h18,
    parameter logic [ADDR_W-1:0] EN_ADDR  = 8'h30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPINS-1:0]     raw_pins,
    input  logic                 ms_tick,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [2*NPINS-1:0]   bus_wdata,
    output logic [NPINS-1:0]     pin_out
);

    localparam int unsigned DATA_W = 2 * NPINS;

    logic [CNT_W-1:0] dbc_time;
    logic [NPINS-1:0] pin_en;

    dbn_regs #(
        .NPINS    (NPINS),
        .CNT_W    (CNT_W),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .CNT_ADDR (CNT_ADDR),
        .EN_ADDR  (EN_ADDR)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .dbc_time  (dbc_time),
        .pin_en    (pin_en)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        dbn_pin_fsm #(
            .CNT_W (CNT_W)
        ) pin_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (raw_pins[i]),
            .tick    (ms_tick),
            .enable  (pin_en[i]),
            .limit   (dbc_time),
            .pin_out (pin_out[i])
        );
    end

    // R4: a disabled pin tracks its raw input in every cycle
    a_r4_disabled_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ raw_pins) & ~pin_en) == '0);

    // R5: with a zero time every pin follows its raw input
    a_r5_zero_time_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (dbc_time == '0) |-> (pin_out == raw_pins));

endmodule

// File: tb/dbn_port_filter_tb_top.sv
module dbn_port_filter_tb_top;

    typedef struct {
        int         cyc;
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  raw_pins = 8'h00;
    logic        ms_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [7:0]  pin_out;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    dbn_port_filter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_pins  (raw_pins),
        .ms_tick   (ms_tick),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_out   (pin_out)
    );

    // Monitor: count edges, compare due items 2 ns after each edge
    initial begin
        forever begin
            exp_t it;
            @(posedge clk);
            cyc++;
            #2;
            while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
                it = sb_q.pop_front();
                checks++;
                if (it.cyc != cyc || pin_out !== it.val) begin
                    errors++;
                    $display("FAIL %s cyc %0d actual %02h expected %02h",
                             it.tag, cyc, pin_out, it.val);
                end
            end
        end
    end

    task automatic push_exp(input logic [7:0] v, input string tag);
        exp_t it;
        it.cyc = cyc + 1;
        it.val = v;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic set_raw(input logic [7:0] v, input logic [7:0] e, input string tag);
        @(negedge clk);
        raw_pins = v;
        push_exp(e, tag);
    endtask

    task automatic hold(input logic [7:0] e, input string tag);
        @(negedge clk);
        push_exp(e, tag);
    endtask

    task automatic pulse(input logic [7:0] e, input string tag);
        @(negedge clk);
        ms_tick = 1'b1;
        push_exp(e, tag);
        @(negedge clk);
        ms_tick = 1'b0;
        push_exp(e, tag);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        bus_addr = 8'h00;
        bus_wdata = 16'h0000;
    endtask

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        push_exp(8'h00, "R1 reset level");
        hold(8'h00, "R1 reset level");

        // R1/R4: nothing configured, all pins pass through
        set_raw(8'hA5, 8'hA5, "R4 pass-through");
        set_raw(8'h3C, 8'h3C, "R4 pass-through");

        // R2/R3: time 3, filter pins 0..3; R10: output holds
        bus_write(8'h18, 16'h0003);
        bus_write(8'h30, 16'h0F0F);
        hold(8'h3C, "R10 enable glitch-free");
        hold(8'h3C, "R10 enable glitch-free");

        // R6: upper pins immediate, lower after third tick
        set_raw(8'hC3, 8'hCC, "R6 before tick");
        pulse(8'hCC, "R6 tick1");
        pulse(8'hCC, "R6 tick2");
        pulse(8'hC3, "R6 tick3 commit");

        // R7: cancel then restart from zero
        set_raw(8'hC2, 8'hC3, "R7 start");
        pulse(8'hC3, "R7 tick1");
        set_raw(8'hC3, 8'hC3, "R7 cancel");
        pulse(8'hC3, "R7 idle tick");
        pulse(8'hC3, "R7 idle tick");
        pulse(8'hC3, "R7 idle tick");
        set_raw(8'hC2, 8'hC3, "R7 restart");
        pulse(8'hC3, "R7 restart tick1");
        pulse(8'hC3, "R7 restart tick2");
        pulse(8'hC2, "R7 restart tick3 commit");

        // R8: two pins start timing one tick apart
        set_raw(8'hC0, 8'hC2, "R8 pin1 start");
        pulse(8'hC2, "R8 pin1 tick1");
        set_raw(8'hC1, 8'hC2, "R8 pin0 start");
        pulse(8'hC2, "R8 ticks 2/1");
        pulse(8'hC0, "R8 pin1 commit");
        pulse(8'hC1, "R8 pin0 commit");

        // R9: stray address changes nothing
        bus_write(8'h44, 16'hFFFF);
        set_raw(8'hD5, 8'hD1, "R9 upper bypass kept");
        pulse(8'hD1, "R9 tick1");
        pulse(8'hD1, "R9 tick2");
        pulse(8'hD5, "R9 time kept at 3");

        // R2: largest time, 255 ticks
        bus_write(8'h18, 16'h00FF);
        set_raw(8'hD1, 8'hD5, "R2 max start");
        for (int k = 1; k < 255; k++) begin
            pulse(8'hD5, "R2 max waiting");
        end
        pulse(8'hD1, "R2 max tick255 commit");

        // R5: zero time with enables on is pass-through
        bus_write(8'h18, 16'h0000);
        set_raw(8'hD5, 8'hD5, "R5 zero time");

        // R3: masked write disables pin0 only
        bus_write(8'h18, 16'h0003);
        bus_write(8'h30, 16'h0100);
        set_raw(8'hDA, 8'hD4, "R3 pin0 off, others kept");
        pulse(8'hD4, "R3 tick1");
        pulse(8'hD4, "R3 tick2");
        pulse(8'hDA, "R3 tick3 commit");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R1 scoreboard left %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog cyc %0d expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule